// File: doc/BRIEF.md
# Packet-mode I2C master sequencer

This block is the command front end of an I2C master. Software describes each transfer as a packet of 32-bit words pushed into a transmit FIFO. The packet is a three-word header followed by the payload. The sequencer takes the header apart and then steps a byte-level bus engine through START, address, data bytes with acknowledge, and a closing STOP or repeated START. Write bytes come out of the payload words, and read bytes are gathered into words and pushed into a receive FIFO.

Each transfer ends with a sticky status flag: complete, no-acknowledge or arbitration lost. Software clears these flags by writing ones to them. Both FIFOs report how full they are. The bit-level serializer sits behind a simple request/done handshake. A soft-clear input brings the whole block back to its empty, idle state.

Top module: `i2c_pkt_master`

## Requirements
- R1: A packet starts with three header words popped in order. The first word is consumed and its contents are not used. In the second word, bits [11:0] hold the byte count minus one. In the third word, bits [7:1] hold the 7-bit target address, bit 19 selects read (1) or write (0), and bit 16 asks for a repeated-START ending. The address byte sent is {address, read bit}.
- R2: A payload of N bytes (size field + 1) takes ceil(N/4) words. A size field of 0 moves exactly one byte.
- R3: On a write, bytes are sent lowest byte lane first. In a final partial word, the lanes above the last byte are never sent.
- R4: On a read, bytes are packed lowest lane first and each word is pushed to the receive FIFO. In a final partial word, the unused upper lanes read as zero.
- R5: On a read, the master acknowledges every received byte except the last, which gets eng_mack=0.
- R6: The bus commands for one packet are issued in this order: START (code 0), SEND of the address (code 1), the data steps (SEND 1 or RECV 2), then STOP (code 3). When the repeat-start bit is set, RESTART (code 4) replaces STOP. A packet without errors sets the complete flag (stat_flags bit 0).
- R7: If the address or any write byte is not acknowledged (eng_nack with eng_done), the block sets the no-acknowledge flag (bit 1) and issues STOP. It then pops and discards the packet's unfetched payload words and goes idle. The complete flag is not set.
- R8: If arbitration is lost (eng_arb_lost with eng_done), the block sets the arbitration flag (bit 2) and issues no further bus command. It discards the packet's unfetched payload words. The complete flag is not set.
- R9: A status flag stays set until stat_clr_we is pulsed with a 1 in that bit of stat_clr_mask. A 0 in the mask leaves the flag unchanged.
- R10: tx_free_cnt equals the FIFO depth (8) minus the number of words held. rx_fill_cnt equals the number of words held in the receive FIFO.
- R11: A one-cycle soft_clr empties both FIFOs, clears all flags and returns the sequencer to idle, so the next word pushed is taken as a new header word one.
- R12: eng_req, eng_cmd and eng_wbyte stay constant from the rise of eng_req until eng_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| soft_clr | input | 1 | Soft clear of FIFOs, flags and sequencer |
| tx_push | input | 1 | Push tx_wdata into the transmit FIFO |
| tx_wdata | input | 32 | Header or payload word |
| tx_free_cnt | output | 4 | Empty slots in the transmit FIFO |
| rx_pop | input | 1 | Pop the head of the receive FIFO |
| rx_rdata | output | 32 | Head word of the receive FIFO |
| rx_fill_cnt | output | 4 | Words held in the receive FIFO |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_mask | input | 3 | Flags to clear (write one to clear) |
| stat_flags | output | 3 | {arbitration lost, no-acknowledge, complete} |
| eng_req | output | 1 | Bus command request |
| eng_cmd | output | 3 | Bus command code |
| eng_wbyte | output | 8 | Byte to send for SEND |
| eng_mack | output | 1 | Master acknowledge for RECV |
| eng_done | input | 1 | One-cycle completion of the current command |
| eng_rbyte | input | 8 | Byte received by RECV, valid with eng_done |
| eng_nack | input | 1 | Target did not acknowledge, valid with eng_done |
| eng_arb_lost | input | 1 | Arbitration lost, valid with eng_done |

## Verification
The assertions take three things for granted about the engine and software. First, the engine raises eng_done only while eng_req is high, for exactly one cycle per command. Second, it flags no-acknowledge only on SEND. Third, software pushes whole packets and never pushes into a full FIFO. The bench's engine model waits for a request, holds it for a fixed latency and then answers with a single done pulse. The bench pushes words only while tx_free_cnt is non-zero, so both FIFO bounds hold throughout.

// File: rtl/i2c_pkt_pkg.sv
// Package: shared command codes, header field positions and sequencer states.
package i2c_pkt_pkg;

    typedef enum logic [2:0] {
        ECMD_START  = 3'd0,
        ECMD_SEND   = 3'd1,
        ECMD_RECV   = 3'd2,
        ECMD_STOP   = 3'd3,
        ECMD_RSTART = 3'd4
    } eng_cmd_t;

    localparam int HDR_ADDR_LSB = 1;
    localparam int HDR_RS_BIT   = 16;
    localparam int HDR_RD_BIT   = 19;

    localparam int FLG_DONE = 0;
    localparam int FLG_NACK = 1;
    localparam int FLG_ARB  = 2;

    typedef enum logic [3:0] {
        SQ_IDLE, SQ_HDR2, SQ_HDR3, SQ_START, SQ_ADDR, SQ_WFETCH,
        SQ_WBYTE, SQ_RBYTE, SQ_RPUSH, SQ_END, SQ_ASTOP, SQ_FLUSH
    } seq_state_t;

endpackage

// File: rtl/i2c_pkt_fifo.sv
// Synchronous word FIFO with an occupancy count.
// Assumes: a push while full and a pop while empty are ignored; clr has priority.
module i2c_pkt_fifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty,
    output logic [CW-1:0]    count
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    // Purpose: store a pushed word.
    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    // Purpose: advance the pointers and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/i2c_pkt_status.sv
// Sticky status flags, write one to clear.
// Assumes: in the same cycle, a set has priority over a clear of the same flag.
module i2c_pkt_status #(
    parameter int NFLAG = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NFLAG-1:0] set,
    input  logic             clr_we,
    input  logic [NFLAG-1:0] clr_mask,
    output logic [NFLAG-1:0] flags
);
    // Purpose: hold each flag until software writes a one to it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) flags <= '0;
        else               flags <= (flags & ~(clr_we ? clr_mask : '0)) | set;
    end
endmodule

// File: rtl/i2c_pkt_seq.sv
// Packet sequencer: decodes the header words and runs the bus-engine command steps.
// Assumes: software pushes whole packets, and the engine answers every request
// with exactly one eng_done pulse.
module i2c_pkt_seq
    import i2c_pkt_pkg::*;
#(
    parameter int SIZE_W = 12,
    localparam int BC_W = SIZE_W + 1,
    localparam int WC_W = SIZE_W - 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic [31:0] tx_head,
    input  logic        tx_empty,
    output logic        tx_pop,
    input  logic        rx_full,
    output logic        rx_push,
    output logic [31:0] rx_word,
    output logic [2:0]  flag_set,
    output logic        eng_req,
    output eng_cmd_t    eng_cmd,
    output logic [7:0]  eng_wbyte,
    output logic        eng_mack,
    input  logic        eng_done,
    input  logic [7:0]  eng_rbyte,
    input  logic        eng_nack,
    input  logic        eng_arb_lost
);
    seq_state_t       st, st_n;
    logic [BC_W-1:0]  bytes_left, bytes_left_n;
    logic [WC_W-1:0]  words_left, words_left_n;
    logic [1:0]       lane, lane_n;
    logic [31:0]      shreg, shreg_n;
    logic [31:0]      acc, acc_n;
    logic [6:0]       taddr, taddr_n;
    logic             rd, rd_n, rs, rs_n;

    assign rx_word = acc;

    // Purpose: next-state, handshake outputs and FIFO strobes.
    always_comb begin
        st_n = st; bytes_left_n = bytes_left; words_left_n = words_left;
        lane_n = lane; shreg_n = shreg; acc_n = acc;
        taddr_n = taddr; rd_n = rd; rs_n = rs;
        tx_pop = 1'b0; rx_push = 1'b0; flag_set = '0;
        eng_req = 1'b0; eng_cmd = ECMD_START; eng_wbyte = '0; eng_mack = 1'b0;
        unique case (st)
            SQ_IDLE: if (!tx_empty) begin tx_pop = 1'b1; st_n = SQ_HDR2; end
            SQ_HDR2: if (!tx_empty) begin
                tx_pop       = 1'b1;
                bytes_left_n = BC_W'(tx_head[SIZE_W-1:0]) + 1'b1;
                words_left_n = WC_W'(tx_head[SIZE_W-1:2]) + 1'b1;
                st_n         = SQ_HDR3;
            end
            SQ_HDR3: if (!tx_empty) begin
                tx_pop  = 1'b1;
                taddr_n = tx_head[HDR_ADDR_LSB +: 7];
                rd_n    = tx_head[HDR_RD_BIT];
                rs_n    = tx_head[HDR_RS_BIT];
                if (tx_head[HDR_RD_BIT]) words_left_n = '0;
                st_n    = SQ_START;
            end
            SQ_START: begin
                eng_req = 1'b1; eng_cmd = ECMD_START;
                if (eng_done) begin
                    if (eng_arb_lost) begin flag_set[FLG_ARB] = 1'b1; st_n = SQ_FLUSH; end
                    else st_n = SQ_ADDR;
                end
            end
            SQ_ADDR: begin
                eng_req = 1'b1; eng_cmd = ECMD_SEND; eng_wbyte = {taddr, rd};
                lane_n = '0; acc_n = '0;
                if (eng_done) begin
                    if (eng_arb_lost)  begin flag_set[FLG_ARB] = 1'b1; st_n = SQ_FLUSH; end
                    else if (eng_nack) begin flag_set[FLG_NACK] = 1'b1; st_n = SQ_ASTOP; end
                    else st_n = rd ? SQ_RBYTE : SQ_WFETCH;
                end
            end
            SQ_WFETCH: if (!tx_empty) begin
                tx_pop = 1'b1; shreg_n = tx_head;
                words_left_n = words_left - 1'b1;
                st_n = SQ_WBYTE;
            end
            SQ_WBYTE: begin
                eng_req = 1'b1; eng_cmd = ECMD_SEND; eng_wbyte = shreg[7:0];
                if (eng_done) begin
                    if (eng_arb_lost)  begin flag_set[FLG_ARB] = 1'b1; st_n = SQ_FLUSH; end
                    else if (eng_nack) begin flag_set[FLG_NACK] = 1'b1; st_n = SQ_ASTOP; end
                    else begin
                        shreg_n      = shreg >> 8;
                        bytes_left_n = bytes_left - 1'b1;
                        lane_n       = lane + 1'b1;
                        if (bytes_left == BC_W'(1)) st_n = SQ_END;
                        else if (lane == 2'd3)      st_n = SQ_WFETCH;
                    end
                end
            end
            SQ_RBYTE: begin
                eng_req = 1'b1; eng_cmd = ECMD_RECV;
                eng_mack = (bytes_left != BC_W'(1));
                if (eng_done) begin
                    if (eng_arb_lost) begin flag_set[FLG_ARB] = 1'b1; st_n = SQ_FLUSH; end
                    else begin
                        acc_n[{lane, 3'b000} +: 8] = eng_rbyte;
                        bytes_left_n = bytes_left - 1'b1;
                        lane_n       = lane + 1'b1;
                        if (lane == 2'd3 || bytes_left == BC_W'(1)) st_n = SQ_RPUSH;
                    end
                end
            end
            SQ_RPUSH: if (!rx_full) begin
                rx_push = 1'b1; acc_n = '0;
                st_n = (bytes_left == '0) ? SQ_END : SQ_RBYTE;
            end
            SQ_END: begin
                eng_req = 1'b1; eng_cmd = rs ? ECMD_RSTART : ECMD_STOP;
                if (eng_done) begin
                    if (eng_arb_lost) flag_set[FLG_ARB] = 1'b1;
                    else              flag_set[FLG_DONE] = 1'b1;
                    st_n = SQ_IDLE;
                end
            end
            SQ_ASTOP: begin
                eng_req = 1'b1; eng_cmd = ECMD_STOP;
                if (eng_done) begin
                    if (eng_arb_lost) flag_set[FLG_ARB] = 1'b1;
                    st_n = SQ_FLUSH;
                end
            end
            SQ_FLUSH: begin
                if (words_left == '0) st_n = SQ_IDLE;
                else if (!tx_empty) begin
                    tx_pop = 1'b1; words_left_n = words_left - 1'b1;
                end
            end
            default: st_n = SQ_IDLE;
        endcase
    end

    // Purpose: register the sequencer state and packet context.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            st <= SQ_IDLE; bytes_left <= '0; words_left <= '0; lane <= '0;
            shreg <= '0; acc <= '0; taddr <= '0; rd <= 1'b0; rs <= 1'b0;
        end else begin
            st <= st_n; bytes_left <= bytes_left_n; words_left <= words_left_n;
            lane <= lane_n; shreg <= shreg_n; acc <= acc_n;
            taddr <= taddr_n; rd <= rd_n; rs <= rs_n;
        end
    end
endmodule

// File: rtl/i2c_pkt_master.sv
// Top: transmit FIFO, packet sequencer, receive FIFO and status flags.
// Assumes: the engine behind eng_* answers each request with one eng_done pulse.
module i2c_pkt_master
    import i2c_pkt_pkg::*;
#(
    parameter int FIFO_DEPTH = 8,
    parameter int SIZE_W     = 12,
    localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          tx_push,
    input  logic [31:0]   tx_wdata,
    output logic [CW-1:0] tx_free_cnt,
    input  logic          rx_pop,
    output logic [31:0]   rx_rdata,
    output logic [CW-1:0] rx_fill_cnt,
    input  logic          stat_clr_we,
    input  logic [2:0]    stat_clr_mask,
    output logic [2:0]    stat_flags,
    output logic          eng_req,
    output logic [2:0]    eng_cmd,
    output logic [7:0]    eng_wbyte,
    output logic          eng_mack,
    input  logic          eng_done,
    input  logic [7:0]    eng_rbyte,
    input  logic          eng_nack,
    input  logic          eng_arb_lost
);
    logic [31:0]   tx_head, rx_word;
    logic          tx_empty, tx_full, tx_pop, rx_full, rx_empty, rx_push;
    logic [CW-1:0] tx_cnt;
    logic [2:0]    flag_set;
    eng_cmd_t      cmd_e;

    assign tx_free_cnt = CW'(FIFO_DEPTH) - tx_cnt;
    assign eng_cmd     = cmd_e;

    i2c_pkt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_head),
        .full(tx_full), .empty(tx_empty), .count(tx_cnt)
    );

    i2c_pkt_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop), .rdata(rx_rdata),
        .full(rx_full), .empty(rx_empty), .count(rx_fill_cnt)
    );

    i2c_pkt_seq #(.SIZE_W(SIZE_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .tx_head(tx_head), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_full(rx_full), .rx_push(rx_push), .rx_word(rx_word),
        .flag_set(flag_set),
        .eng_req(eng_req), .eng_cmd(cmd_e), .eng_wbyte(eng_wbyte), .eng_mack(eng_mack),
        .eng_done(eng_done), .eng_rbyte(eng_rbyte), .eng_nack(eng_nack),
        .eng_arb_lost(eng_arb_lost)
    );

    i2c_pkt_status #(.NFLAG(3)) u_stat (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .set(flag_set),
        .clr_we(stat_clr_we), .clr_mask(stat_clr_mask), .flags(stat_flags)
    );
endmodule

// File: rtl/i2c_pkt_master_chk.sv
// Checker: port-level properties of the packet master, bound to the top.
// Assumes: the engine pulses eng_done only while eng_req is high.
module i2c_pkt_master_chk #(
    parameter int DEPTH = 8,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          soft_clr,
    input logic [CW-1:0] tx_free_cnt,
    input logic [CW-1:0] rx_fill_cnt,
    input logic          stat_clr_we,
    input logic [2:0]    stat_clr_mask,
    input logic [2:0]    stat_flags,
    input logic          eng_req,
    input logic [2:0]    eng_cmd,
    input logic [7:0]    eng_wbyte,
    input logic          eng_done,
    input logic          eng_nack,
    input logic          eng_arb_lost
);
    // R12: a pending request keeps its command and byte until done
    a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (eng_req && !eng_done) |=> (eng_req && $stable(eng_cmd) && $stable(eng_wbyte)));

    // R10: occupancy counts never exceed the depth
    a_r10_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_free_cnt <= CW'(DEPTH)) && (rx_fill_cnt <= CW'(DEPTH)));

    // R11: soft clear leaves empty FIFOs, no flags and no request
    a_r11_soft_clr: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (stat_flags == 3'b000 && tx_free_cnt == CW'(DEPTH)
                      && rx_fill_cnt == '0 && !eng_req));

    // R8: arbitration loss stops command issue
    a_r8_arb_stops: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (eng_req && eng_done && eng_arb_lost) |=> !eng_req);

    // R7: a refused SEND is followed by a STOP request
    a_r7_stop_after_nack: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
        (eng_req && eng_done && eng_cmd == 3'd1 && eng_nack && !eng_arb_lost)
        |=> (eng_req && eng_cmd == 3'd3));

    // R9: a flag stays set until a one is written to it
    for (genvar k = 0; k < 3; k++) begin : g_sticky
        a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
            (stat_flags[k] && !(stat_clr_we && stat_clr_mask[k])) |=> stat_flags[k]);
    end
endmodule

bind i2c_pkt_master i2c_pkt_master_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .tx_free_cnt(tx_free_cnt), .rx_fill_cnt(rx_fill_cnt),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask), .stat_flags(stat_flags),
    .eng_req(eng_req), .eng_cmd(eng_cmd), .eng_wbyte(eng_wbyte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost)
);

// File: tb/i2c_pkt_master_test.sv
// Directed bench with a behavioural bus-engine model that logs every command.
module i2c_pkt_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        soft_clr = 1'b0;
    logic        tx_push = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic [3:0]  tx_free_cnt;
    logic        rx_pop = 1'b0;
    logic [31:0] rx_rdata;
    logic [3:0]  rx_fill_cnt;
    logic        stat_clr_we = 1'b0;
    logic [2:0]  stat_clr_mask = '0;
    logic [2:0]  stat_flags;
    logic        eng_req;
    logic [2:0]  eng_cmd;
    logic [7:0]  eng_wbyte;
    logic        eng_mack;
    logic        eng_done = 1'b0;
    logic [7:0]  eng_rbyte = '0;
    logic        eng_nack = 1'b0;
    logic        eng_arb_lost = 1'b0;

    int total = 0;
    int bad = 0;

    logic [2:0] lg_cmd [0:31];
    logic [7:0] lg_val [0:31];
    int lg_n = 0, send_n = 0, rx_k = 0, nack_at = -1, arb_at = -1;

    always #2.5 clk = ~clk;

    i2c_pkt_master uut (.*);

    // Engine model: answers each request after a fixed latency.
    initial begin
        forever begin
            @(negedge clk);
            if (eng_req && rst_n) begin
                automatic int idx = lg_n;
                automatic logic [2:0] c = eng_cmd;
                lg_cmd[idx] = c;
                lg_val[idx] = (c == 3'd1) ? eng_wbyte : (c == 3'd2) ? {7'd0, eng_mack} : 8'd0;
                lg_n = lg_n + 1;
                repeat (2) @(negedge clk);
                eng_arb_lost = (idx == arb_at);
                eng_nack     = (c == 3'd1) && (send_n == nack_at);
                if (c == 3'd1) send_n = send_n + 1;
                if (c == 3'd2) begin eng_rbyte = 8'hA0 + 8'(rx_k); rx_k = rx_k + 1; end
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0; eng_nack = 1'b0; eng_arb_lost = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad = bad + 1; total = total + 1;
        $display("FAIL watchdog: run did not finish, act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic new_log(input int nk, input int ak);
        lg_n = 0; send_n = 0; rx_k = 0; nack_at = nk; arb_at = ak;
    endtask

    task automatic chk_log(input string tag, input int i, input logic [2:0] c, input logic [7:0] v);
        chk({tag, " cmd"}, 32'(lg_cmd[i]), 32'(c));
        chk({tag, " val"}, 32'(lg_val[i]), 32'(v));
    endtask

    task automatic push_word(input logic [31:0] w);
        @(negedge clk);
        while (tx_free_cnt == 0) @(negedge clk);
        tx_push = 1'b1; tx_wdata = w;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic push_hdr(input logic [6:0] a, input logic rd, input logic rs, input int n);
        push_word(32'h0001_0010);
        push_word(32'(n - 1));
        push_word((32'(a) << 1) | (32'(rd) << 19) | (32'(rs) << 16));
    endtask

    task automatic wait_end;
        for (int i = 0; i < 3000 && stat_flags == 3'b000; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic clr_flags(input logic [2:0] m);
        @(negedge clk);
        stat_clr_we = 1'b1; stat_clr_mask = m;
        @(negedge clk);
        stat_clr_we = 1'b0; stat_clr_mask = '0;
    endtask

    task automatic pop_rx(input string tag, input logic [31:0] exp);
        @(negedge clk);
        chk(tag, rx_rdata, exp);
        rx_pop = 1'b1;
        @(negedge clk);
        rx_pop = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 reset tx_free", 32'(tx_free_cnt), 32'd8);
        chk("R10 reset rx_fill", 32'(rx_fill_cnt), 32'd0);
        chk("R11 reset flags", 32'(stat_flags), 32'd0);
        chk("R12 reset req", 32'(eng_req), 32'd0);
    endtask

    task automatic t_write6;
        new_log(-1, -1);
        push_hdr(7'h52, 1'b0, 1'b0, 6);
        push_word(32'h4433_2211);
        push_word(32'h00BB_6655);
        wait_end;
        chk("R6 write6 count", 32'(lg_n), 32'd9);
        chk_log("R6 write6 start", 0, 3'd0, 8'h00);
        chk_log("R1 write6 addr", 1, 3'd1, 8'hA4);
        chk_log("R3 write6 b0", 2, 3'd1, 8'h11);
        chk_log("R3 write6 b3", 5, 3'd1, 8'h44);
        chk_log("R3 write6 b4", 6, 3'd1, 8'h55);
        chk_log("R3 write6 b5", 7, 3'd1, 8'h66);
        chk_log("R6 write6 stop", 8, 3'd3, 8'h00);
        chk("R6 write6 flags", 32'(stat_flags), 32'b001);
        chk("R10 write6 tx_free", 32'(tx_free_cnt), 32'd8);
        clr_flags(3'b111);
    endtask

    task automatic t_read5_rs;
        new_log(-1, -1);
        push_hdr(7'h1D, 1'b1, 1'b1, 5);
        wait_end;
        chk("R6 read5 count", 32'(lg_n), 32'd8);
        chk_log("R1 read5 addr", 1, 3'd1, 8'h3B);
        for (int i = 0; i < 4; i++) chk_log("R5 read5 ack", 2 + i, 3'd2, 8'h01);
        chk_log("R5 read5 last nack", 6, 3'd2, 8'h00);
        chk_log("R6 read5 restart", 7, 3'd4, 8'h00);
        chk("R6 read5 flags", 32'(stat_flags), 32'b001);
        chk("R10 read5 rx_fill", 32'(rx_fill_cnt), 32'd2);
        pop_rx("R4 read5 word0", 32'hA3A2_A1A0);
        pop_rx("R4 read5 word1 zero lanes", 32'h0000_00A4);
        chk("R10 read5 rx_fill after", 32'(rx_fill_cnt), 32'd0);
        clr_flags(3'b111);
    endtask

    task automatic t_nack_data;
        new_log(2, -1);
        push_hdr(7'h50, 1'b0, 1'b0, 9);
        push_word(32'h0403_0201);
        push_word(32'h0807_0605);
        push_word(32'h0000_0009);
        wait_end;
        chk("R7 data nack count", 32'(lg_n), 32'd5);
        chk_log("R7 data nack b1", 3, 3'd1, 8'h02);
        chk_log("R7 data nack stop", 4, 3'd3, 8'h00);
        chk("R7 data nack flags", 32'(stat_flags), 32'b010);
        chk("R7 data nack flushed", 32'(tx_free_cnt), 32'd8);
        clr_flags(3'b111);
    endtask

    task automatic t_nack_addr;
        new_log(0, -1);
        push_hdr(7'h7F, 1'b0, 1'b0, 4);
        push_word(32'hDEAD_BEEF);
        wait_end;
        chk("R7 addr nack count", 32'(lg_n), 32'd3);
        chk_log("R7 addr nack byte", 1, 3'd1, 8'hFE);
        chk_log("R7 addr nack stop", 2, 3'd3, 8'h00);
        chk("R7 addr nack flags", 32'(stat_flags), 32'b010);
        chk("R7 addr nack flushed", 32'(tx_free_cnt), 32'd8);
    endtask

    task automatic t_w1c;
        chk("R9 flag held", 32'(stat_flags), 32'b010);
        clr_flags(3'b101);
        chk("R9 other bits no effect", 32'(stat_flags), 32'b010);
        clr_flags(3'b010);
        chk("R9 cleared", 32'(stat_flags), 32'b000);
    endtask

    task automatic t_arb;
        new_log(-1, 0);
        push_hdr(7'h11, 1'b0, 1'b0, 5);
        push_word(32'h1111_1111);
        push_word(32'h0000_0022);
        wait_end;
        chk("R8 arb count", 32'(lg_n), 32'd1);
        chk("R8 arb flags", 32'(stat_flags), 32'b100);
        chk("R8 arb flushed", 32'(tx_free_cnt), 32'd8);
        chk("R8 arb no req", 32'(eng_req), 32'd0);
        clr_flags(3'b111);
    endtask

    task automatic t_soft_clr;
        new_log(-1, -1);
        push_hdr(7'h33, 1'b1, 1'b0, 4);
        wait_end;
        chk_log("R5 read4 last", 5, 3'd2, 8'h00);
        chk_log("R6 read4 stop", 6, 3'd3, 8'h00);
        chk("R4 read4 rx_fill", 32'(rx_fill_cnt), 32'd1);
        chk("R4 read4 word", rx_rdata, 32'hA3A2_A1A0);
        push_word(32'h0001_0010);
        repeat (4) @(negedge clk);
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
        chk("R11 soft rx_fill", 32'(rx_fill_cnt), 32'd0);
        chk("R11 soft flags", 32'(stat_flags), 32'd0);
        chk("R11 soft tx_free", 32'(tx_free_cnt), 32'd8);
    endtask

    task automatic t_write1;
        new_log(-1, -1);
        push_hdr(7'h05, 1'b0, 1'b0, 1);
        push_word(32'hFFFF_FF5A);
        wait_end;
        chk("R2 write1 count", 32'(lg_n), 32'd4);
        chk_log("R11 write1 addr after clear", 1, 3'd1, 8'h0A);
        chk_log("R2 write1 byte", 2, 3'd1, 8'h5A);
        chk_log("R2 write1 stop", 3, 3'd3, 8'h00);
        chk("R2 write1 flags", 32'(stat_flags), 32'b001);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write6;
        t_read5_rs;
        t_nack_data;
        t_nack_addr;
        t_w1c;
        t_arb;
        t_soft_clr;
        t_write1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule